// File: doc/BRIEF.md
# DDR Write Data-Phase Strobe Sequencer

This block produces the data-phase timing of a DDR SDRAM write transaction once the write command has gone out. It runs on a clock at twice the DDR clock, so one cycle of `clk_i` is half a DDR clock. A one-cycle `start_i` pulse marks the reference step after the write command. From that pulse the block opens the data and strobe drivers with the strobes held low for the preamble. It then toggles the strobes twice for each back-to-back write command and presents write data and masks one beat per strobe edge. It keeps the strobes low for the postamble, runs a write-recovery count, and finally drops the buffer enables and the chip-select hold and pulses `done_o`.

Cycle numbers below count `clk_i` cycles after the cycle in which `start_i` is sampled high (cycle 0). N is the number of write commands after clamping and W is the recovery value after clamping. The completion cycle is C = 2N + 2 + 2(W - 2). Each cycle of `clk_i` is a data window. An external quarter-DDR-clock delay on the strobe puts each strobe edge in the middle of its window.

Top module: `ddr_wr_seq`

## Requirements
- R1: While reset is held and after it is released, with no start, every enable output, `dqs_o`, `done_o`, `beat_req_o`, `dq_o` and `dm_o` are 0.
- R2: In cycle 1 both `dq_oe_o` and `dqs_oe_o` rise while `dqs_o` is still 0 (preamble). `buf_oe_o` (all bits) and `cs_keep_o` are 1 from cycle 1.
- R3: All `dqs_o` bits are 1 in the even cycles 2, 4, ..., 2N and 0 in every other cycle. This gives 2N transitions, rising first, with the last transition (high to low) in cycle 2N+1.
- R4: `beat_req_o` is 1 in cycles 1..2N. The `wdata_i`/`wmask_i` values present in cycle k appear on `dq_o`/`dm_o` in cycle k+1, so beat b is on the bus in cycle b+2. `dq_o`/`dm_o` are otherwise unchanged.
- R5: `dq_oe_o` and `dqs_oe_o` stay 1 through cycle 2N+2 (one DDR clock after the last toggle) and are 0 from the earlier of cycle 2N+3 and cycle C.
- R6: The recovery count starts in cycle 2N+2. `done_o` is 1 for exactly one cycle, cycle C. `buf_oe_o` and `cs_keep_o` are 0 from cycle C onward.
- R7: A recovery value `wr_i` below 2 is treated as 2, so completion falls in cycle 2N+2.
- R8: An `n_wr_i` of 0 is treated as one write command.
- R9: A `start_i` while a transaction is running and before its completion cycle is ignored. A `start_i` in the completion cycle is accepted, and its cycle 1 follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cycle clock (twice the DDR clock) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start at the post-command reference step |
| n_wr_i | input | 3 | Number of back-to-back write commands |
| wr_i | input | 4 | Programmed write-recovery value in DDR clocks |
| wdata_i | input | 32 | Write data for the requested beat |
| wmask_i | input | 8 | Write mask for the requested beat |
| beat_req_o | output | 1 | Asks for the next beat on wdata_i/wmask_i |
| dqs_o | output | 4 | Strobe level |
| dqs_oe_o | output | 1 | Strobe drive enable |
| dq_oe_o | output | 1 | Data and mask drive enable |
| dq_o | output | 32 | Data out |
| dm_o | output | 8 | Data mask out |
| buf_oe_o | output | 4 | Buffer output enables |
| cs_keep_o | output | 1 | Hold chip select active; a fall negates it |
| done_o | output | 1 | One-cycle transaction complete |

## Verification
A single command with the minimum recovery value shows that the postamble is cut short by completion. Two and four commands with larger recovery values separate the strobe count from the recovery length, and seven commands with the largest recovery value test the widest counts. Zero commands and recovery values of 0 and 1 show the clamping. A start pulse in the middle of a burst tells ignoring apart from restarting, and a start in the completion cycle shows that a following transaction can run with no idle cycle between them. Each beat carries a distinct data pattern, so a lost, duplicated or shifted beat shows up.

// File: rtl/ddr_wr_seq_pkg.sv
package ddr_wr_seq_pkg;
  typedef struct packed {
    logic drive;
    logic strobe_hi;
    logic beat_req;
    logic last_tgl;
  } wr_phase_t;
endpackage

// File: rtl/ddr_wr_seq_ctrl.sv
module ddr_wr_seq_ctrl #(
  parameter int CMD_W = 3,
  parameter int WR_W  = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] n_wr_i,
  input  logic [WR_W-1:0]  wr_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CMD_W-1:0] n_o,
  output logic [WR_W-1:0]  wr_o
);
  localparam logic [WR_W-1:0] WR_MIN = WR_W'(2);

  logic accept;
  assign accept = start_i && (!busy_o || done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
      n_o    <= '0;
      wr_o   <= '0;
    end else if (accept) begin
      busy_o <= 1'b1;
      cnt_o  <= CNT_W'(1);
      n_o    <= (n_wr_i == '0) ? CMD_W'(1) : n_wr_i;
      wr_o   <= (wr_i < WR_MIN) ? WR_MIN : wr_i;
    end else if (busy_o) begin
      if (done_i) begin
        busy_o <= 1'b0;
        cnt_o  <= '0;
      end else begin
        cnt_o  <= cnt_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ddr_wr_strobe_gen.sv
module ddr_wr_strobe_gen
  import ddr_wr_seq_pkg::*;
#(
  parameter int CMD_W = 3,
  parameter int CNT_W = 6
) (
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CMD_W-1:0] n_i,
  output wr_phase_t        phase_o
);
  logic [CNT_W-1:0] beats;
  assign beats = CNT_W'(n_i) << 1;

  always_comb begin
    phase_o.drive     = busy_i && !done_i && (cnt_i <= beats + CNT_W'(2));
    phase_o.strobe_hi = busy_i && (cnt_i >= CNT_W'(2)) && (cnt_i <= beats) && !cnt_i[0];
    phase_o.beat_req  = busy_i && (cnt_i <= beats);
    phase_o.last_tgl  = busy_i && (cnt_i == beats + CNT_W'(1));
  end
endmodule

// File: rtl/ddr_wr_data_path.sv
module ddr_wr_data_path #(
  parameter int DQ_W = 32,
  parameter int DM_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            beat_req_i,
  input  logic [DQ_W-1:0] wdata_i,
  input  logic [DM_W-1:0] wmask_i,
  output logic [DQ_W-1:0] dq_o,
  output logic [DM_W-1:0] dm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o <= '0;
      dm_o <= '0;
    end else if (beat_req_i) begin
      dq_o <= wdata_i;
      dm_o <= wmask_i;
    end
  end
endmodule

// File: rtl/ddr_wr_recovery.sv
module ddr_wr_recovery #(
  parameter int WR_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WR_W-1:0] wr_i,
  output logic            done_o
);
  localparam int RC_W = WR_W + 1;

  logic            active;
  logic [RC_W-1:0] rem;

  // half-cycles left: 2*(wr-2), wr already clamped to >= 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      rem    <= '0;
    end else if (load_i) begin
      active <= 1'b1;
      rem    <= (RC_W'(wr_i) - RC_W'(2)) << 1;
    end else if (active) begin
      if (rem == '0) active <= 1'b0;
      else           rem    <= rem - RC_W'(1);
    end
  end

  assign done_o = active && (rem == '0);
endmodule

// File: rtl/ddr_wr_seq.sv
module ddr_wr_seq
  import ddr_wr_seq_pkg::*;
#(
  parameter int CMD_W = 3,
  parameter int WR_W  = 4,
  parameter int DQ_W  = 32,
  parameter int DM_W  = 8,
  parameter int DQS_W = 4,
  parameter int BOE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] n_wr_i,
  input  logic [WR_W-1:0]  wr_i,
  input  logic [DQ_W-1:0]  wdata_i,
  input  logic [DM_W-1:0]  wmask_i,
  output logic             beat_req_o,
  output logic [DQS_W-1:0] dqs_o,
  output logic             dqs_oe_o,
  output logic             dq_oe_o,
  output logic [DQ_W-1:0]  dq_o,
  output logic [DM_W-1:0]  dm_o,
  output logic [BOE_W-1:0] buf_oe_o,
  output logic             cs_keep_o,
  output logic             done_o
);
  localparam int MAX_HC = 2 * (2 ** CMD_W) + 2 * (2 ** WR_W) + 4;
  localparam int CNT_W  = $clog2(MAX_HC) + 1;

  logic             busy, done;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] n_lat;
  logic [WR_W-1:0]  wr_lat;
  wr_phase_t        phase;

  ddr_wr_seq_ctrl #(.CMD_W(CMD_W), .WR_W(WR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk_i, .rst_ni, .start_i, .n_wr_i, .wr_i,
    .done_i(done), .busy_o(busy), .cnt_o(cnt), .n_o(n_lat), .wr_o(wr_lat)
  );

  ddr_wr_strobe_gen #(.CMD_W(CMD_W), .CNT_W(CNT_W)) strobe_i (
    .busy_i(busy), .done_i(done), .cnt_i(cnt), .n_i(n_lat), .phase_o(phase)
  );

  ddr_wr_data_path #(.DQ_W(DQ_W), .DM_W(DM_W)) data_i (
    .clk_i, .rst_ni, .beat_req_i(phase.beat_req),
    .wdata_i, .wmask_i, .dq_o, .dm_o
  );

  ddr_wr_recovery #(.WR_W(WR_W)) rec_i (
    .clk_i, .rst_ni, .load_i(phase.last_tgl), .wr_i(wr_lat), .done_o(done)
  );

  assign beat_req_o = phase.beat_req;
  assign dqs_oe_o   = phase.drive;
  assign dq_oe_o    = phase.drive;
  assign done_o     = done;
  assign cs_keep_o  = busy && !done;

  for (genvar g = 0; g < DQS_W; g++) begin : g_dqs
    assign dqs_o[g] = phase.strobe_hi;
  end
  for (genvar g = 0; g < BOE_W; g++) begin : g_boe
    assign buf_oe_o[g] = busy && !done;
  end
endmodule

// File: rtl/ddr_wr_seq_chk.sv
module ddr_wr_seq_chk #(
  parameter int DQ_W  = 32,
  parameter int DQS_W = 4,
  parameter int BOE_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             beat_req_o,
  input logic [DQS_W-1:0] dqs_o,
  input logic             dqs_oe_o,
  input logic             dq_oe_o,
  input logic [DQ_W-1:0]  dq_o,
  input logic [BOE_W-1:0] buf_oe_o,
  input logic             cs_keep_o,
  input logic             done_o
);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_cs_fall_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_keep_o) |-> done_o);
  a_r5_drive_inside_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> buf_oe_o[0]);
  a_r3_strobe_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_o != '0) |-> dqs_oe_o);
  a_r2_preamble_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_oe_o) |-> (dqs_o == '0));
  a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_req_o |=> $stable(dq_o));
endmodule

bind ddr_wr_seq ddr_wr_seq_chk #(.DQ_W(DQ_W), .DQS_W(DQS_W), .BOE_W(BOE_W)) chk_i (
  .clk_i, .rst_ni, .beat_req_o, .dqs_o, .dqs_oe_o, .dq_oe_o, .dq_o,
  .buf_oe_o, .cs_keep_o, .done_o
);

// File: tb/ddr_wr_seq_tb_top.sv
module ddr_wr_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  n_wr_i = '0;
  logic [3:0]  wr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [7:0]  wmask_i = '0;
  logic        beat_req_o, dqs_oe_o, dq_oe_o, cs_keep_o, done_o;
  logic [3:0]  dqs_o, buf_oe_o;
  logic [31:0] dq_o;
  logic [7:0]  dm_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  ddr_wr_seq dut_i (.*);

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h @%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int seed, input int b);
    return 32'hA500_0000 ^ (32'h0101_0101 * (b + 1)) ^ seed;
  endfunction

  // Runs one transaction; cycle 1 is the negedge following the accept edge.
  task automatic run_txn(input int n, input int wr, input int seed,
                         input bit started, input bit poke_mid,
                         input bit chain, input int nn, input int nwr);
    int nc, wc, c, last;
    nc = (n == 0) ? 1 : n;
    wc = (wr < 2) ? 2 : wr;
    c  = 2 * nc + 2 + 2 * (wc - 2);
    if (!started) begin
      n_wr_i = 3'(n); wr_i = 4'(wr); start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    last = chain ? c : c + 1;
    for (int k = 1; k <= last; k++) begin
      logic exp_drv;
      exp_drv = (k <= 2 * nc + 2) && (k < c);
      if (k == 1) check("R2", "dqs preamble", {dqs_oe_o, dq_oe_o, dqs_o}, {2'b11, 4'h0});
      check("R5", "dq_oe", dq_oe_o, exp_drv);
      check("R5", "dqs_oe", dqs_oe_o, exp_drv);
      check("R3", "dqs", dqs_o, (k >= 2 && k <= 2 * nc && k % 2 == 0) ? 4'hF : 4'h0);
      check("R4", "beat_req", beat_req_o, k <= 2 * nc);
      check("R6", "buf_oe", {buf_oe_o, cs_keep_o}, (k < c) ? 5'h1F : 5'h0);
      check("R6", "done", done_o, k == c);
      if (k >= 2 && k <= 2 * nc + 1) begin
        check("R4", "dq", dq_o, pat(seed, k - 2));
        check("R4", "dm", dm_o, 8'(pat(seed, k - 2) >> 3));
      end
      if (k == c && wr < 2) check("R7", "clamped completion", k, 2 * nc + 2);
      if (k == c && n == 0) check("R8", "single command", k, 2 + 2 * (wc - 2) + 2);
      wdata_i = pat(seed, k - 1);
      wmask_i = 8'(pat(seed, k - 1) >> 3);
      start_i = 1'b0;
      if (poke_mid && k == 3) begin
        start_i = 1'b1; n_wr_i = 3'd5; wr_i = 4'd9; // R9 must be ignored
      end
      if (chain && k == c) begin
        start_i = 1'b1; n_wr_i = 3'(nn); wr_i = 4'(nwr);
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    if (!chain)
      check("R9", "idle after done", {buf_oe_o, dq_oe_o, done_o}, 6'h0);
  endtask

  task automatic t_reset();
    check("R1", "reset outputs", {beat_req_o, dqs_o, dqs_oe_o, dq_oe_o, buf_oe_o, cs_keep_o, done_o}, 0);
    check("R1", "reset data", {dq_o, dm_o}, 0);
  endtask

  task automatic t_idle_after_reset();
    repeat (3) @(negedge clk_i);
    check("R1", "idle outputs", {beat_req_o, dqs_o, dq_oe_o, buf_oe_o, done_o}, 0);
  endtask

  task automatic t_basic();
    run_txn(1, 2, 32'h11, 0, 0, 0, 0, 0);
    run_txn(2, 3, 32'h22, 0, 0, 0, 0, 0);
    run_txn(4, 6, 32'h33, 0, 0, 0, 0, 0);
  endtask

  task automatic t_clamps();
    run_txn(0, 1, 32'h44, 0, 0, 0, 0, 0);
    run_txn(3, 0, 32'h55, 0, 0, 0, 0, 0);
  endtask

  task automatic t_busy_ignore();
    run_txn(2, 4, 32'h66, 0, 1, 0, 0, 0);
  endtask

  task automatic t_chain();
    run_txn(1, 3, 32'h77, 0, 0, 1, 3, 2);
    check("R9", "chained start accepted", {dq_oe_o, dqs_o, cs_keep_o}, 6'b1_0000_1);
    run_txn(3, 2, 32'h88, 1, 0, 0, 0, 0);
  endtask

  task automatic t_max();
    run_txn(7, 15, 32'h99, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1;
    t_reset();
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    t_idle_after_reset();
    t_basic();
    t_clamps();
    t_busy_ignore();
    t_chain();
    t_max();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule